// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Flag Register

This block computes one arithmetic or logic operation per accepted request on 8-bit or 16-bit operands. It supports add, add with carry, subtract, subtract with borrow, AND, OR, XOR and compare. It also supports the two decimal-adjust steps that correct an 8-bit accumulator after packed-BCD addition or subtraction. A nine-bit flag register is held inside the block. Each operation updates only the flags it defines, through a per-operation write mask. Six control commands set or clear the direction, interrupt-enable and single-step bits.

Requests arrive on a valid/ready channel. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The result appears on a registered valid/ready response channel on the following cycle. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response stays frozen and no new request is taken. The flag register is updated at the acceptance edge, so a carry-consuming operation sees the flags left by the request accepted just before it.

Top module: `alu_flag_unit`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are high at a clock edge, and its response is valid at the next edge. `req_ready` is low exactly while a response is held with `rsp_ready` low. A held response keeps `rsp_result`, `rsp_we` and `flags_o` unchanged.
- R2: `req_op` encodes the operations as follows:
  - 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow
  - 4 AND, 5 OR, 6 XOR, 7 compare
  - 8 decimal adjust after addition, 9 decimal adjust after subtraction
  - 10/11 set/clear direction, 12/13 set/clear interrupt enable, 14/15 set/clear single-step

  With `req_wide`=0 only the low 8 bits of the operands are used and the upper result bits are 0. `flags_o` bits 0..8 are: carry, parity, auxiliary, zero, sign, overflow, single-step, interrupt enable, direction.
- R3: Add and subtract write the carry out, or the borrow out, of the selected width into carry. Add with carry and subtract with borrow also add or subtract the current carry flag.
- R4: Parity is 1 when the low 8 bits of the result hold an even number of ones; zero ones counts as even.
- R5: The auxiliary flag is the carry or borrow from bit 3 into bit 4.
- R6: Zero is 1 exactly when the result of the selected width is 0. Sign copies the top bit of the selected width.
- R7: Overflow is 1 when the signed two's-complement result leaves the range of the selected width (80h..7Fh or 8000h..7FFFh).
- R8: AND, OR and XOR clear carry and overflow, write parity, zero and sign, and leave the auxiliary flag unchanged.
- R9: Compare writes the flags exactly as subtract would. It returns operand a (width-masked) with `rsp_we`=0. Every other arithmetic, logic or adjust operation returns `rsp_we`=1.
- R10: Decimal adjust after addition works on the low byte of `req_a`, ignoring `req_b` and `req_wide`:
  - If the low nibble is above 9 or the auxiliary flag is set, it adds 06h and sets the auxiliary flag; otherwise it clears the auxiliary flag.
  - If the original byte is above 99h or carry is set, it adds 60h and sets carry; otherwise it clears carry.
  - It writes parity, zero and sign from the adjusted byte and leaves overflow unchanged.
- R11: Decimal adjust after subtraction follows the same rules as R10 but subtracts 06h and 60h.
- R12: Control commands change only their own bit, return result 0 with `rsp_we`=0, and leave the other eight flags unchanged.
- R13: After reset all flags are 0, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 4 | Operation code (R2) |
| req_wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| req_a | input | 16 | First operand / accumulator |
| req_b | input | 16 | Second operand |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_result | output | 16 | Result value |
| rsp_we | output | 1 | Result should be written back |
| flags_o | output | 9 | Flag register contents |

## Verification
The hardest case to reach is a decimal adjust whose outcome depends on the flags left behind by an earlier operation. It needs both the auxiliary-flag path and the carry path, which only a preceding BCD add or subtract can set up. The stimulus table is therefore an ordered chain in which each entry's expected flags include those carried from the entry before. It runs BCD sums and differences that need a low-nibble fix, a high-nibble fix and both at once. A second hard case is a request offered while the response is stalled; a directed sequence holds the consumer off for several cycles and confirms that the flags and result stay put until the stall ends.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int FLAG_W  = 9;
  localparam int BCD_W   = 8;

  localparam int FL_CY   = 0;
  localparam int FL_PAR  = 1;
  localparam int FL_HC   = 2;
  localparam int FL_ZR   = 3;
  localparam int FL_NEG  = 4;
  localparam int FL_OVF  = 5;
  localparam int FL_STEP = 6;
  localparam int FL_IEN  = 7;
  localparam int FL_DIR  = 8;

  typedef enum logic [3:0] {
    OP_ADD      = 4'd0,
    OP_ADC      = 4'd1,
    OP_SUB      = 4'd2,
    OP_SBB      = 4'd3,
    OP_AND      = 4'd4,
    OP_OR       = 4'd5,
    OP_XOR      = 4'd6,
    OP_CMP      = 4'd7,
    OP_DADD     = 4'd8,
    OP_DSUB     = 4'd9,
    OP_DIR_SET  = 4'd10,
    OP_DIR_CLR  = 4'd11,
    OP_IEN_SET  = 4'd12,
    OP_IEN_CLR  = 4'd13,
    OP_STEP_SET = 4'd14,
    OP_STEP_CLR = 4'd15
  } alu_op_e;

  localparam logic [FLAG_W-1:0] M_ARITH = 9'h03F;
  localparam logic [FLAG_W-1:0] M_LOGIC = 9'h03B;
  localparam logic [FLAG_W-1:0] M_BCD   = 9'h01F;

  function automatic logic [FLAG_W-1:0] flag_mask(input alu_op_e op);
    logic [FLAG_W-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: m = M_ARITH;
      OP_AND, OP_OR, OP_XOR:                  m = M_LOGIC;
      OP_DADD, OP_DSUB:                       m = M_BCD;
      OP_DIR_SET, OP_DIR_CLR:                 m[FL_DIR]  = 1'b1;
      OP_IEN_SET, OP_IEN_CLR:                 m[FL_IEN]  = 1'b1;
      default:                                m[FL_STEP] = 1'b1;
    endcase
    return m;
  endfunction

  function automatic logic op_is_logic(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic op_is_bcd(input alu_op_e op);
    return (op == OP_DADD) || (op == OP_DSUB);
  endfunction

  function automatic logic op_is_ctrl(input alu_op_e op);
    return op >= OP_DIR_SET;
  endfunction

  function automatic logic op_writes_back(input alu_op_e op);
    return !op_is_ctrl(op) && (op != OP_CMP);
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cy_i,
  output logic [DATA_W-1:0] res_o,
  output logic              cy_o,
  output logic              hc_o,
  output logic              ovf_o,
  output logic              par_o,
  output logic              zr_o,
  output logic              neg_o
);
  localparam int HALF_W = DATA_W / 2;
  localparam int NIB    = 4;

  logic [DATA_W-1:0] mask, a_m, b_m, arith_r, logic_r, fv, hx;
  logic [DATA_W:0]   ext;
  logic              is_sub, is_arith, cin_eff, carry;
  logic              a_top, b_top, r_top;

  assign mask     = wide_i ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  assign a_m      = a_i & mask;
  assign b_m      = b_i & mask;
  assign is_sub   = (op_i == OP_SUB) || (op_i == OP_SBB) || (op_i == OP_CMP);
  assign is_arith = is_sub || (op_i == OP_ADD) || (op_i == OP_ADC);
  assign cin_eff  = ((op_i == OP_ADC) || (op_i == OP_SBB)) && cy_i;

  always_comb begin
    if (is_sub)
      ext = {1'b0, a_m} - {1'b0, b_m} - {{DATA_W{1'b0}}, cin_eff};
    else
      ext = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin_eff};
  end

  assign arith_r = ext[DATA_W-1:0] & mask;
  assign carry   = wide_i ? ext[DATA_W] : ext[HALF_W];
  assign hx      = a_m ^ b_m ^ arith_r;

  always_comb begin
    case (op_i)
      OP_AND:  logic_r = a_m & b_m;
      OP_OR:   logic_r = a_m | b_m;
      default: logic_r = a_m ^ b_m;
    endcase
  end

  always_comb begin
    if (op_i == OP_CMP)      res_o = a_m;
    else if (is_arith)       res_o = arith_r;
    else if (op_is_logic(op_i)) res_o = logic_r;
    else                     res_o = '0;
  end

  assign fv    = (op_i == OP_CMP) ? arith_r : res_o;
  assign a_top = wide_i ? a_m[DATA_W-1] : a_m[HALF_W-1];
  assign b_top = wide_i ? b_m[DATA_W-1] : b_m[HALF_W-1];
  assign r_top = wide_i ? fv[DATA_W-1]  : fv[HALF_W-1];

  always_comb begin
    cy_o  = 1'b0;
    ovf_o = 1'b0;
    if (is_arith) begin
      cy_o  = carry;
      ovf_o = is_sub ? ((a_top != b_top) && (r_top != a_top))
                     : ((a_top == b_top) && (r_top != a_top));
    end
  end

  assign hc_o  = hx[NIB];
  assign par_o = ~^fv[BCD_W-1:0];
  assign zr_o  = (fv == '0);
  assign neg_o = r_top;

  // R4: a zero result holds no ones, so its parity must read even
  always_comb begin
    a_r4_zero_is_even: assert (!zr_o || par_o)
      else $error("zero result without even parity");
  end

  // R2: byte mode leaves the upper half of the result clear
  always_comb begin
    a_r2_byte_upper_clear: assert (wide_i || (res_o[DATA_W-1:HALF_W] == '0))
      else $error("byte mode result has upper bits");
  end

endmodule

// File: rtl/alu_bcd_adjust.sv
module alu_bcd_adjust
  import alu_flag_pkg::*;
(
  input  logic             sub_i,
  input  logic [BCD_W-1:0] al_i,
  input  logic             cy_i,
  input  logic             hc_i,
  output logic [BCD_W-1:0] al_o,
  output logic             cy_o,
  output logic             hc_o
);
  localparam logic [BCD_W-1:0] LOW_FIX  = 8'h06;
  localparam logic [BCD_W-1:0] HIGH_FIX = 8'h60;
  localparam logic [BCD_W-1:0] HIGH_LIM = 8'h99;
  localparam logic [3:0]       DIG_MAX  = 4'd9;

  logic             low_need, high_need;
  logic [BCD_W-1:0] mid;

  assign low_need  = (al_i[3:0] > DIG_MAX) || hc_i;
  assign high_need = (al_i > HIGH_LIM) || cy_i;

  always_comb begin
    mid = al_i;
    if (low_need)
      mid = sub_i ? (al_i - LOW_FIX) : (al_i + LOW_FIX);
    al_o = mid;
    if (high_need)
      al_o = sub_i ? (mid - HIGH_FIX) : (mid + HIGH_FIX);
  end

  assign hc_o = low_need;
  assign cy_o = high_need;

  // R10: a valid packed-BCD byte with no pending carries passes unchanged
  always_comb begin
    if (!sub_i && !hc_i && !cy_i && (al_i[3:0] <= DIG_MAX) && (al_i[7:4] <= DIG_MAX))
      a_r10_clean_bcd_kept: assert (al_o == al_i)
        else $error("clean BCD byte altered");
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] mask_i,
  input  logic [FLAG_W-1:0] nxt_i,
  output logic [FLAG_W-1:0] flags_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)
      flags_q <= '0;
    else if (wr_en)
      flags_q <= (flags_q & ~mask_i) | (nxt_i & mask_i);
  end

  // R1: no accepted request, no flag change
  a_r1_idle_flags_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags_q));

  // R12: bits outside the operation's mask survive a write
  a_r12_unmasked_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((flags_q & ~$past(mask_i)) == ($past(flags_q) & ~$past(mask_i))));

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_result,
  output logic              rsp_we,
  output logic [FLAG_W-1:0] flags_o
);

  alu_op_e           op;
  logic              fire;
  logic [DATA_W-1:0] ar_res, res_nxt;
  logic              ar_cy, ar_hc, ar_ovf, ar_par, ar_zr, ar_neg;
  logic [BCD_W-1:0]  bcd_al;
  logic              bcd_cy, bcd_hc;
  logic [FLAG_W-1:0] flag_nxt, flag_msk;

  assign op        = alu_op_e'(req_op);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i   (op),
    .wide_i (req_wide),
    .a_i    (req_a),
    .b_i    (req_b),
    .cy_i   (flags_o[FL_CY]),
    .res_o  (ar_res),
    .cy_o   (ar_cy),
    .hc_o   (ar_hc),
    .ovf_o  (ar_ovf),
    .par_o  (ar_par),
    .zr_o   (ar_zr),
    .neg_o  (ar_neg)
  );

  alu_bcd_adjust u_bcd (
    .sub_i (op == OP_DSUB),
    .al_i  (req_a[BCD_W-1:0]),
    .cy_i  (flags_o[FL_CY]),
    .hc_i  (flags_o[FL_HC]),
    .al_o  (bcd_al),
    .cy_o  (bcd_cy),
    .hc_o  (bcd_hc)
  );

  always_comb begin
    flag_nxt = '0;
    if (op_is_bcd(op)) begin
      flag_nxt[FL_CY]  = bcd_cy;
      flag_nxt[FL_HC]  = bcd_hc;
      flag_nxt[FL_PAR] = ~^bcd_al;
      flag_nxt[FL_ZR]  = (bcd_al == '0);
      flag_nxt[FL_NEG] = bcd_al[BCD_W-1];
    end else begin
      flag_nxt[FL_CY]  = ar_cy;
      flag_nxt[FL_HC]  = ar_hc;
      flag_nxt[FL_PAR] = ar_par;
      flag_nxt[FL_ZR]  = ar_zr;
      flag_nxt[FL_NEG] = ar_neg;
      flag_nxt[FL_OVF] = ar_ovf;
    end
    flag_nxt[FL_DIR]  = (op == OP_DIR_SET);
    flag_nxt[FL_IEN]  = (op == OP_IEN_SET);
    flag_nxt[FL_STEP] = (op == OP_STEP_SET);
  end

  assign flag_msk = flag_mask(op);

  always_comb begin
    if (op_is_bcd(op))      res_nxt = {{(DATA_W-BCD_W){1'b0}}, bcd_al};
    else if (op_is_ctrl(op)) res_nxt = '0;
    else                    res_nxt = ar_res;
  end

  alu_flag_reg u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fire),
    .mask_i  (flag_msk),
    .nxt_i   (flag_nxt),
    .flags_q (flags_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= '0;
      rsp_we     <= 1'b0;
    end else if (fire) begin
      rsp_valid  <= 1'b1;
      rsp_result <= res_nxt;
      rsp_we     <= op_writes_back(op);
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  // R1: a stalled response is held unchanged
  a_r1_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_result) && $stable(rsp_we));

  // R1: an accepted request yields a response next cycle
  a_r1_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R9: compare never asks for a write-back
  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (op == OP_CMP) |=> !rsp_we);

  // R8: logic operations leave carry and overflow clear
  a_r8_logic_clears_cy_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_is_logic(op) |=> !flags_o[FL_CY] && !flags_o[FL_OVF]);

  // R12: control commands leave the six status flags alone
  a_r12_ctrl_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    fire && op_is_ctrl(op) |=> flags_o[FL_OVF:FL_CY] == $past(flags_o[FL_OVF:FL_CY]));

endmodule

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;

  typedef struct packed {
    logic [3:0]  op;
    logic        wide;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic [8:0]  flg;
  } vec_t;

  localparam int NV = 28;
  // Ordered chain: each entry's flags include those left by the one before.
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd0,  1'b0, 16'h007E, 16'h0002, 16'h0080, 9'h034},
    '{4'd0,  1'b0, 16'h00FF, 16'h0001, 16'h0000, 9'h00F},
    '{4'd1,  1'b0, 16'h0010, 16'h0020, 16'h0031, 9'h000},
    '{4'd2,  1'b1, 16'h0000, 16'h0001, 16'hFFFF, 9'h017},
    '{4'd3,  1'b1, 16'h8000, 16'h0000, 16'h7FFF, 9'h026},
    '{4'd4,  1'b1, 16'hF0F0, 16'h0FF0, 16'h00F0, 9'h006},
    '{4'd5,  1'b0, 16'h0000, 16'h0000, 16'h0000, 9'h00E},
    '{4'd6,  1'b1, 16'h8001, 16'h0000, 16'h8001, 9'h014},
    '{4'd7,  1'b1, 16'h1234, 16'h1234, 16'h1234, 9'h00A},
    '{4'd7,  1'b0, 16'h0005, 16'h0007, 16'h0005, 9'h015},
    '{4'd0,  1'b0, 16'h0038, 16'h0045, 16'h007D, 9'h002},
    '{4'd8,  1'b0, 16'h007D, 16'h0000, 16'h0083, 9'h014},
    '{4'd0,  1'b0, 16'h0099, 16'h0001, 16'h009A, 9'h012},
    '{4'd8,  1'b0, 16'h009A, 16'h0000, 16'h0000, 9'h00F},
    '{4'd2,  1'b0, 16'h0042, 16'h0015, 16'h002D, 9'h006},
    '{4'd9,  1'b0, 16'h002D, 16'h0000, 16'h0027, 9'h006},
    '{4'd2,  1'b0, 16'h0010, 16'h0020, 16'h00F0, 9'h013},
    '{4'd9,  1'b0, 16'h00F0, 16'h0000, 16'h0090, 9'h013},
    '{4'd10, 1'b0, 16'h5555, 16'hAAAA, 16'h0000, 9'h113},
    '{4'd12, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 9'h193},
    '{4'd14, 1'b0, 16'h0000, 16'h0000, 16'h0000, 9'h1D3},
    '{4'd0,  1'b1, 16'h7FFF, 16'h0001, 16'h8000, 9'h1F6},
    '{4'd13, 1'b0, 16'h0000, 16'h0000, 16'h0000, 9'h176},
    '{4'd15, 1'b0, 16'h0000, 16'h0000, 16'h0000, 9'h136},
    '{4'd11, 1'b0, 16'h0000, 16'h0000, 16'h0000, 9'h036},
    '{4'd0,  1'b1, 16'hFFFF, 16'hFFFF, 16'hFFFE, 9'h015},
    '{4'd1,  1'b0, 16'h12FF, 16'h3400, 16'h0000, 9'h00F},
    '{4'd3,  1'b1, 16'h0000, 16'hFFFF, 16'h0000, 9'h00F}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic        req_wide = 1'b0;
  logic [15:0] req_a = '0;
  logic [15:0] req_b = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_result;
  logic        rsp_we;
  logic [8:0]  flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_wide   (req_wide),
    .req_a      (req_a),
    .req_b      (req_b),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_result (rsp_result),
    .rsp_we     (rsp_we),
    .flags_o    (flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [3:0] op);
    if (op <= 4'd3)      return "R3 result";
    else if (op <= 4'd6) return "R8 result";
    else if (op == 4'd7) return "R9 result";
    else if (op == 4'd8) return "R10 result";
    else if (op == 4'd9) return "R11 result";
    else                 return "R12 result";
  endfunction

  function automatic logic exp_we(input logic [3:0] op);
    return (op <= 4'd6) || (op == 4'd8) || (op == 4'd9);
  endfunction

  // Drive one request with the consumer ready; response sampled one cycle later.
  task automatic run_op(input logic [3:0] op, input logic wide,
                        input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    req_op = op; req_wide = wide; req_a = a; req_b = b;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    chk("R13 flags after reset", 32'(flags_o), 32'h0);
    chk("R13 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R13 req_ready after reset", 32'(req_ready), 32'h1);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i].op, VEC[i].wide, VEC[i].a, VEC[i].b);
      chk("R1 rsp_valid after accept", 32'(rsp_valid), 32'h1);
      chk(op_tag(VEC[i].op), 32'(rsp_result), 32'(VEC[i].res));
      chk("R4/R5/R6/R7 flags", 32'(flags_o), 32'(VEC[i].flg));
      chk("R2 R9 write-back", 32'(rsp_we), 32'(exp_we(VEC[i].op)));
    end

    // R10 R2: adjust ignores req_b and req_wide, uses only the low byte of req_a
    run_op(4'd8, 1'b1, 16'hAB12, 16'hFFFF);
    chk("R10 adjust ignores upper byte", 32'(rsp_result), 32'h0078);
    chk("R10 adjust flags", 32'(flags_o), 32'h007);

    // R1: back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_op = 4'd0; req_wide = 1'b0; req_a = 16'h0001; req_b = 16'h0001;
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_a = 16'h0003; req_b = 16'h0003;
    chk("R1 ready low under stall", 32'(req_ready), 32'h0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 held result", 32'(rsp_result), 32'h0002);
      chk("R1 held flags", 32'(flags_o), 32'h000);
      chk("R1 held valid", 32'(rsp_valid), 32'h1);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 second request result", 32'(rsp_result), 32'h0006);
    chk("R1 second request flags", 32'(flags_o), 32'h002);
    @(negedge clk);
    chk("R1 response drained", 32'(rsp_valid), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule